// File: doc/BRIEF.md
# Capacitive Touch Baseline Tracker and Detector

This block sits behind a capacitive sensing front end and turns a stream of raw counts into touch decisions. One raw count arrives per scan strobe, tagged with the index of the sensor it belongs to. For each sensor the block keeps a slowly moving baseline, reports how far the current raw count sits above it (the difference count), and decides whether that sensor is touched. The decision uses a finger threshold widened by a hysteresis band, and a debounce that asks for several consecutive qualifying scans before a touch is reported.

The baseline follows the raw count through a first-order low-pass step. Software picks one of two update policies: follow on every scan, or follow only while the difference stays below a noise threshold, so that a held finger is not absorbed into the baseline. A separate recovery path handles a raw count that falls well below the baseline. If this persists for a programmed number of consecutive scans of that sensor, the baseline jumps straight to the raw count. All state is kept per sensor, so scans of different sensors may be interleaved in any order.

Top module: `touch_track`

## Requirements
- R1: While and after synchronous reset, `touch`, `any_touch` and `diff_valid` are 0, and every sensor is marked as not yet scanned.
- R2: The first scan of a sensor after reset loads its baseline with the raw count, reports a difference of 0 and leaves its touch flag at 0.
- R3: On the clock edge that takes a strobe, the block registers `diff_count` = raw count minus that sensor's baseline (held at 0 when the raw count is lower) and `diff_sel` = the strobed index. Both appear with `diff_valid` = 1 in the next cycle. Full-scale raw counts (2^CNT_W − 1) do not wrap.
- R4: A sensor whose flag is 0 sets it once the difference has been strictly greater than threshold + hysteresis on `cfg_debounce` consecutive scans of that sensor. A non-qualifying scan restarts the count. A debounce value of 0 or 1 sets the flag on the first qualifying scan.
- R5: A sensor whose flag is 1 clears it on the first scan where the difference is strictly below threshold − hysteresis (taken as 0 when hysteresis ≥ threshold). Differences between the two limits keep the flag at 1.
- R6: When the baseline follows, it becomes baseline + floor((raw − baseline) / 8), rounded toward minus infinity.
- R7: With `cfg_autoreset` = 1 the baseline follows on every scan. With it at 0 it follows only when the difference is strictly below `cfg_noise_thr`, and otherwise it stays unchanged.
- R8: A scan where raw + `cfg_neg_noise_thr` < baseline counts one low scan. When `cfg_low_reset` consecutive low scans of that sensor have occurred (0 is taken as 1), the baseline is set to that raw count and the low counter clears. That scan does no following. A scan that is not low clears the counter.
- R9: Each of the NUM_SENS sensors keeps its own baseline, debounce count, low count and flag. A scan changes only the state of the strobed sensor.
- R10: `any_touch` equals the OR of all `touch` bits in every cycle.
- R11: A cycle with no strobe leaves `diff_valid` at 0 and changes no touch flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_valid | input | 1 | Scan strobe: a raw count is present |
| raw_sel | input | SEL_W | Sensor index of the raw count |
| raw_count | input | CNT_W | Raw count from the front end |
| cfg_finger_thr | input | THR_W | Finger threshold |
| cfg_hyst | input | THR_W | Hysteresis around the threshold |
| cfg_noise_thr | input | THR_W | Follow limit used when autoreset is off |
| cfg_neg_noise_thr | input | THR_W | Margin below baseline that counts as a low scan |
| cfg_low_reset | input | LBR_W | Consecutive low scans before the baseline is snapped |
| cfg_debounce | input | DB_W | Consecutive qualifying scans before a touch is reported |
| cfg_autoreset | input | 1 | 1: baseline follows on every scan |
| diff_valid | output | 1 | Difference result valid this cycle |
| diff_count | output | CNT_W | Difference count of the last scan |
| diff_sel | output | SEL_W | Sensor index of the last scan |
| touch | output | NUM_SENS | Per-sensor touch flags |
| any_touch | output | 1 | OR of all touch flags |

## Verification
A corrupted baseline shows up at the next scan of the same sensor as a wrong `diff_count`, one cycle after that strobe. A wrong baseline step, a wrong follow policy or a missed snap shows up the same way. Debounce and low-count errors stay hidden until the sensor's own scan sequence reaches its limit. They then appear as a touch flag or a difference that changes one scan early or one scan late. The bench therefore runs sequences of consecutive scans on one sensor, including interrupted runs and runs interleaved with scans of other sensors. It compares every output with a behavioural model on every cycle.

// File: rtl/touch_pkg.sv
package touch_pkg;
  // What happens to the baseline of the strobed sensor on one scan.
  typedef enum logic [1:0] {
    BL_SEED   = 2'd0,  // first scan after reset: load raw count
    BL_KEEP   = 2'd1,  // hold the baseline
    BL_FOLLOW = 2'd2,  // low-pass step toward the raw count
    BL_SNAP   = 2'd3   // low-count recovery: load raw count
  } bl_act_e;
endpackage

// File: rtl/tt_state_ram.sv
module tt_state_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 28,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/tt_detect.sv
module tt_detect #(
  parameter int CNT_W = 16,
  parameter int THR_W = 8,
  parameter int DB_W  = 4
) (
  input  logic [CNT_W-1:0] diff,
  input  logic             on_cur,
  input  logic [DB_W-1:0]  db_cur,
  input  logic [THR_W-1:0] thr,
  input  logic [THR_W-1:0] hyst,
  input  logic [DB_W-1:0]  deb,
  output logic             on_nxt,
  output logic [DB_W-1:0]  db_nxt
);
  localparam int CW = CNT_W + THR_W + 1;

  logic [CW-1:0]   up_lim, lo_lim, dz;
  logic [DB_W:0]   need, cnt1;

  always_comb begin
    dz     = CW'(diff);
    up_lim = CW'(thr) + CW'(hyst);
    lo_lim = (thr > hyst) ? (CW'(thr) - CW'(hyst)) : '0;
    need   = (deb == '0) ? (DB_W+1)'(1) : {1'b0, deb};
    cnt1   = {1'b0, db_cur} + (DB_W+1)'(1);
  end

  always_comb begin
    on_nxt = on_cur;
    db_nxt = '0;
    if (!on_cur) begin
      if (dz > up_lim) begin
        if (cnt1 >= need) on_nxt = 1'b1;
        else              db_nxt = DB_W'(cnt1);
      end
    end else if (dz < lo_lim) begin
      on_nxt = 1'b0;
    end
  end
endmodule

// File: rtl/tt_baseline.sv
module tt_baseline
  import touch_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 8,
  parameter int LBR_W = 8,
  parameter int SHIFT = 3
) (
  input  logic             seen,
  input  logic [CNT_W-1:0] raw,
  input  logic [CNT_W-1:0] base,
  input  logic [LBR_W-1:0] low_cur,
  input  logic [CNT_W-1:0] diff,
  input  logic [THR_W-1:0] neg_thr,
  input  logic [THR_W-1:0] noise_thr,
  input  logic [LBR_W-1:0] low_need,
  input  logic             autoreset,
  output bl_act_e          act,
  output logic [CNT_W-1:0] base_nxt,
  output logic [LBR_W-1:0] low_nxt
);
  localparam int EW = CNT_W + THR_W + 2;

  logic [EW-1:0]        raw_plus, base_ext;
  logic                 is_low;
  logic [LBR_W:0]       need, cnt1;
  logic signed [EW-1:0] err, step, sum;

  always_comb begin
    raw_plus = EW'(raw) + EW'(neg_thr);
    base_ext = EW'(base);
    is_low   = raw_plus < base_ext;
    need     = (low_need == '0) ? (LBR_W+1)'(1) : {1'b0, low_need};
    cnt1     = {1'b0, low_cur} + (LBR_W+1)'(1);
    err      = $signed(EW'(raw)) - $signed(base_ext);
    step     = err >>> SHIFT;
    sum      = $signed(base_ext) + step;
  end

  always_comb begin
    if (!seen)                                        act = BL_SEED;
    else if (is_low && cnt1 >= need)                  act = BL_SNAP;
    else if (autoreset || (EW'(diff) < EW'(noise_thr))) act = BL_FOLLOW;
    else                                              act = BL_KEEP;
  end

  always_comb begin
    case (act)
      BL_SEED, BL_SNAP: base_nxt = raw;
      BL_FOLLOW:        base_nxt = CNT_W'(sum);
      default:          base_nxt = base;
    endcase
    low_nxt = (seen && is_low && act != BL_SNAP) ? LBR_W'(cnt1) : '0;
  end
endmodule

// File: rtl/touch_track.sv
module touch_track
  import touch_pkg::*;
#(
  parameter int NUM_SENS = 8,
  parameter int CNT_W    = 16,
  parameter int THR_W    = 8,
  parameter int LBR_W    = 8,
  parameter int DB_W     = 4,
  parameter int SHIFT    = 3,
  parameter int SEL_W    = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                raw_valid,
  input  logic [SEL_W-1:0]    raw_sel,
  input  logic [CNT_W-1:0]    raw_count,
  input  logic [THR_W-1:0]    cfg_finger_thr,
  input  logic [THR_W-1:0]    cfg_hyst,
  input  logic [THR_W-1:0]    cfg_noise_thr,
  input  logic [THR_W-1:0]    cfg_neg_noise_thr,
  input  logic [LBR_W-1:0]    cfg_low_reset,
  input  logic [DB_W-1:0]     cfg_debounce,
  input  logic                cfg_autoreset,
  output logic                diff_valid,
  output logic [CNT_W-1:0]    diff_count,
  output logic [SEL_W-1:0]    diff_sel,
  output logic [NUM_SENS-1:0] touch,
  output logic                any_touch
);
  localparam int ST_W = CNT_W + LBR_W + DB_W;

  logic [ST_W-1:0]     rd_word, wr_word;
  logic [CNT_W-1:0]    cur_base, base_nxt, diff_c;
  logic [LBR_W-1:0]    cur_low, low_nxt;
  logic [DB_W-1:0]     cur_db, det_db, db_w;
  logic                cur_seen, cur_on, det_on, on_w;
  logic [NUM_SENS-1:0] seen_q, on_q, on_next_vec;
  bl_act_e             bl_act;

  // Per-sensor counters and baseline in one inferable memory.
  tt_state_ram #(.DEPTH(NUM_SENS), .WIDTH(ST_W), .AW(SEL_W)) u_ram (
    .clk   (clk),
    .we    (raw_valid),
    .addr  (raw_sel),
    .wdata (wr_word),
    .rdata (rd_word)
  );

  assign {cur_base, cur_low, cur_db} = rd_word;
  assign cur_seen = seen_q[raw_sel];
  assign cur_on   = on_q[raw_sel] & cur_seen;

  always_comb begin
    if (cur_seen && (raw_count > cur_base)) diff_c = raw_count - cur_base;
    else                                    diff_c = '0;
  end

  tt_detect #(.CNT_W(CNT_W), .THR_W(THR_W), .DB_W(DB_W)) u_det (
    .diff   (diff_c),
    .on_cur (cur_on),
    .db_cur (cur_seen ? cur_db : '0),
    .thr    (cfg_finger_thr),
    .hyst   (cfg_hyst),
    .deb    (cfg_debounce),
    .on_nxt (det_on),
    .db_nxt (det_db)
  );

  tt_baseline #(.CNT_W(CNT_W), .THR_W(THR_W), .LBR_W(LBR_W), .SHIFT(SHIFT)) u_bl (
    .seen      (cur_seen),
    .raw       (raw_count),
    .base      (cur_base),
    .low_cur   (cur_seen ? cur_low : '0),
    .diff      (diff_c),
    .neg_thr   (cfg_neg_noise_thr),
    .noise_thr (cfg_noise_thr),
    .low_need  (cfg_low_reset),
    .autoreset (cfg_autoreset),
    .act       (bl_act),
    .base_nxt  (base_nxt),
    .low_nxt   (low_nxt)
  );

  assign on_w    = cur_seen ? det_on : 1'b0;
  assign db_w    = cur_seen ? det_db : '0;
  assign wr_word = {base_nxt, low_nxt, db_w};

  always_comb begin
    on_next_vec = on_q;
    if (raw_valid) begin
      for (int k = 0; k < NUM_SENS; k++) begin
        if (raw_sel == SEL_W'(k)) on_next_vec[k] = on_w;
      end
    end
  end

  // Per-sensor flag registers.
  for (genvar g = 0; g < NUM_SENS; g++) begin : g_sens
    always_ff @(posedge clk) begin
      if (rst) begin
        seen_q[g] <= 1'b0;
        on_q[g]   <= 1'b0;
      end else if (raw_valid && raw_sel == SEL_W'(g)) begin
        seen_q[g] <= 1'b1;
        on_q[g]   <= on_w;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_valid <= 1'b0;
      diff_count <= '0;
      diff_sel   <= '0;
      any_touch  <= 1'b0;
    end else begin
      diff_valid <= raw_valid;
      any_touch  <= |on_next_vec;
      if (raw_valid) begin
        diff_count <= diff_c;
        diff_sel   <= raw_sel;
      end
    end
  end

  assign touch = on_q;
endmodule

// File: rtl/touch_track_chk.sv
module touch_track_chk #(
  parameter int NUM_SENS = 8,
  parameter int CNT_W    = 16,
  parameter int THR_W    = 8,
  parameter int SEL_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                raw_valid,
  input logic [SEL_W-1:0]    raw_sel,
  input logic [THR_W-1:0]    cfg_finger_thr,
  input logic [THR_W-1:0]    cfg_hyst,
  input logic                diff_valid,
  input logic [CNT_W-1:0]    diff_count,
  input logic [SEL_W-1:0]    diff_sel,
  input logic [NUM_SENS-1:0] touch,
  input logic                any_touch
);
  localparam int CW = CNT_W + THR_W + 1;

  logic [CW-1:0]       up_q, lo_q;
  logic [NUM_SENS-1:0] prev_touch;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_touch <= '0;
      up_q       <= '0;
      lo_q       <= '0;
    end else begin
      prev_touch <= touch;
      up_q       <= CW'(cfg_finger_thr) + CW'(cfg_hyst);
      lo_q       <= (cfg_finger_thr > cfg_hyst) ? (CW'(cfg_finger_thr) - CW'(cfg_hyst)) : '0;
    end
  end

  a_r11_strobe_valid: assert property (@(posedge clk) disable iff (rst)
    raw_valid |=> diff_valid);
  a_r11_idle_novalid: assert property (@(posedge clk) disable iff (rst)
    !raw_valid |=> !diff_valid);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !raw_valid |=> $stable(touch));
  a_r3_sel_follow: assert property (@(posedge clk) disable iff (rst)
    raw_valid |=> (diff_sel == $past(raw_sel)));
  a_r10_any_or: assert property (@(posedge clk) disable iff (rst)
    any_touch == (|touch));
  a_r9_one_change: assert property (@(posedge clk) disable iff (rst)
    $countones(touch ^ prev_touch) <= 1);
  a_r4_rise_above: assert property (@(posedge clk) disable iff (rst)
    (diff_valid && touch[diff_sel] && !prev_touch[diff_sel]) |-> (CW'(diff_count) > up_q));
  a_r5_fall_below: assert property (@(posedge clk) disable iff (rst)
    (diff_valid && !touch[diff_sel] && prev_touch[diff_sel]) |-> (CW'(diff_count) < lo_q));
endmodule

bind touch_track touch_track_chk #(
  .NUM_SENS(NUM_SENS), .CNT_W(CNT_W), .THR_W(THR_W), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/tb_touch_track.sv
module tb_touch_track;
  localparam int NS = 8;
  localparam int CW = 16;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          raw_valid = 1'b0;
  logic [SW-1:0] raw_sel = '0;
  logic [CW-1:0] raw_count = '0;
  logic [7:0]    cfg_finger_thr = 8'd40, cfg_hyst = 8'd5, cfg_noise_thr = 8'd10;
  logic [7:0]    cfg_neg_noise_thr = 8'd20, cfg_low_reset = 8'd3;
  logic [3:0]    cfg_debounce = 4'd3;
  logic          cfg_autoreset = 1'b0;
  logic          diff_valid, any_touch;
  logic [CW-1:0] diff_count;
  logic [SW-1:0] diff_sel;
  logic [NS-1:0] touch;

  int nchecks = 0, nerr = 0;
  bit started = 0, done = 0;

  always #2 clk = ~clk;

  touch_track dut (.*);

  // Behavioural reference model
  int m_base[NS], m_low[NS], m_db[NS];
  bit m_seen[NS], m_on[NS];
  bit exp_valid;
  int exp_diff, exp_sel;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) begin m_seen[i] = 0; m_on[i] = 0; m_low[i] = 0; m_db[i] = 0; end
      exp_valid = 0; exp_diff = 0; exp_sel = 0;
    end else begin
      exp_valid = raw_valid;
      if (raw_valid) begin
        int s, r, d, up, lo, need_db, need_lo;
        bit snapped;
        s = int'(raw_sel); r = int'(raw_count); snapped = 0;
        exp_sel = s;
        if (!m_seen[s]) begin
          m_seen[s] = 1; m_base[s] = r; m_low[s] = 0; m_db[s] = 0; m_on[s] = 0; exp_diff = 0;
        end else begin
          d  = (r > m_base[s]) ? r - m_base[s] : 0;
          exp_diff = d;
          up = int'(cfg_finger_thr) + int'(cfg_hyst);
          lo = (cfg_finger_thr > cfg_hyst) ? int'(cfg_finger_thr) - int'(cfg_hyst) : 0;
          need_db = (cfg_debounce == 0) ? 1 : int'(cfg_debounce);
          need_lo = (cfg_low_reset == 0) ? 1 : int'(cfg_low_reset);
          if (!m_on[s]) begin
            if (d > up) begin
              m_db[s]++;
              if (m_db[s] >= need_db) begin m_on[s] = 1; m_db[s] = 0; end
            end else m_db[s] = 0;
          end else begin
            m_db[s] = 0;
            if (d < lo) m_on[s] = 0;
          end
          if (r + int'(cfg_neg_noise_thr) < m_base[s]) begin
            m_low[s]++;
            if (m_low[s] >= need_lo) begin m_base[s] = r; m_low[s] = 0; snapped = 1; end
          end else m_low[s] = 0;
          if (!snapped && (cfg_autoreset || d < int'(cfg_noise_thr)))
            m_base[s] = m_base[s] + ((r - m_base[s]) >>> 3);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Every-cycle comparison with the model
  always @(negedge clk) begin
    if (started && !rst && !done) begin
      logic [NS-1:0] et;
      for (int i = 0; i < NS; i++) et[i] = m_on[i];
      chk(diff_valid == exp_valid, "R11 diff_valid", int'(diff_valid), int'(exp_valid));
      if (exp_valid) begin
        chk(int'(diff_count) == exp_diff, "R3 diff_count", int'(diff_count), exp_diff);
        chk(int'(diff_sel) == exp_sel, "R3 diff_sel", int'(diff_sel), exp_sel);
      end
      chk(touch == et, "R4 R5 touch", int'(touch), int'(et));
      chk(any_touch == (|et), "R10 any_touch", int'(any_touch), int'(|et));
    end
  end

  task automatic scan(input int s, input int r);
    raw_valid = 1'b1; raw_sel = SW'(s); raw_count = CW'(r);
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic exp_diff_is(input string tag, input int e);
    chk(diff_valid && int'(diff_count) == e, tag, int'(diff_count), e);
  endtask

  task automatic exp_touch_bit(input string tag, input int s, input bit e);
    chk(touch[s] == e, tag, int'(touch[s]), int'(e));
  endtask

  task automatic report();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(touch == '0, "R1 touch in reset", int'(touch), 0);
    chk(!any_touch && !diff_valid, "R1 flags in reset", int'({any_touch, diff_valid}), 0);
    rst = 1'b0;
    started = 1;
    @(negedge clk);
    chk(touch == '0 && !diff_valid, "R1 after reset", int'(touch), 0);

    // R2: first scan seeds baseline
    scan(0, 1000); exp_diff_is("R2 first diff", 0); exp_touch_bit("R2 first touch", 0, 0);
    scan(0, 1030); exp_diff_is("R3 diff value", 30);
    scan(0, 990);  exp_diff_is("R3 saturate at zero", 0);   // base -> 998
    // R4 debounce of 3, R7 held baseline with autoreset off
    scan(0, 1060); exp_touch_bit("R4 scan1", 0, 0);
    scan(0, 1060); exp_diff_is("R7 baseline held", 62); exp_touch_bit("R4 scan2", 0, 0);
    scan(0, 1060); exp_touch_bit("R4 scan3 sets", 0, 1);
    chk(any_touch, "R10 any set", int'(any_touch), 1);
    exp_touch_bit("R9 neighbour clear", 1, 0);
    // R5 hysteresis
    scan(0, 1040); exp_touch_bit("R5 inside band holds", 0, 1);
    scan(0, 1032); exp_touch_bit("R5 below lower clears", 0, 0);
    chk(!any_touch, "R10 any clear", int'(any_touch), 0);
    // R4 restart, R9 interleaving
    scan(0, 1060); scan(0, 1060); scan(0, 1000);
    scan(0, 1060); exp_touch_bit("R4 restarted count", 0, 0);
    scan(1, 200);
    scan(0, 1060); exp_touch_bit("R9 other sensor no effect", 0, 0);
    scan(0, 1060); exp_touch_bit("R9 rise after interleave", 0, 1);
    scan(0, 900);  exp_touch_bit("R5 clear", 0, 0);
    // R6 follow step with autoreset
    cfg_autoreset = 1'b1;
    scan(2, 500); scan(2, 580); exp_diff_is("R6 diff before step", 80);
    scan(2, 510); exp_diff_is("R6 step of eighth", 0);
    scan(2, 526); scan(2, 520); exp_diff_is("R6 second step", 8);
    cfg_autoreset = 1'b0;
    // R8 low-baseline snap
    scan(3, 800); scan(3, 770); scan(3, 770); scan(3, 770);
    scan(3, 780); exp_diff_is("R8 snapped baseline", 10);
    // R8 interrupted run
    scan(5, 800); scan(5, 770); scan(5, 770); scan(5, 795); scan(5, 770);
    scan(5, 800); exp_diff_is("R8 run interrupted", 11);
    // R4 debounce 0
    cfg_debounce = 4'd0;
    scan(4, 200); scan(4, 260); exp_touch_bit("R4 debounce zero", 4, 1);
    scan(4, 100); exp_touch_bit("R5 clear s4", 4, 0);
    // R3 full scale
    scan(6, 0); scan(6, 65535); exp_diff_is("R3 full scale", 65535);
    cfg_debounce = 4'd2;
    // R11 idle
    @(negedge clk); @(negedge clk);
    chk(!diff_valid, "R11 idle no valid", int'(diff_valid), 0);
    // Mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) cfg_autoreset = ~cfg_autoreset;
      scan(int'($urandom_range(0, NS-1)), 960 + int'($urandom_range(0, 120)));
      if (n % 7 == 0) @(negedge clk);
    end
    report();
  end
endmodule